// File: doc/BRIEF.md
# Pipelined Taylor-Series Floating-Point Divider

This block divides one floating-point number by another in a fixed number of clock cycles and accepts a new operand pair every cycle. Each operand carries a sign bit, a biased exponent field and a fraction with a hidden leading one. The block does not use an iterative digit loop. It splits the divisor significand into a high part and a low part. A table addressed by the high part supplies the reciprocal square of that part. The quotient significand then comes from two multiplications: the dividend times (high part minus low part), and that product times the table value. This is the divisor's Taylor expansion cut after its linear term.

The result sign is the XOR of the operand signs. The result exponent is the exponent difference with the bias added back. A one-bit normalization step at the output brings the quotient significand from the range (0.5, 2) back into [1, 2) and lowers the exponent when it shifts. An exception flag travels with each operation. The flag is raised when the divisor is zero, when the caller flags the input, or when the result exponent leaves the representable range. Final rounding is not done: the significand is truncated.

The widths come from two parameters. `EXP_W` is the exponent width. `M` is half the significand width, so the fraction is 2M−1 bits. The defaults are `EXP_W`=5 and `M`=6, which give 17-bit words, a bias of 15 and a 64-entry table.

Top module: `taylor_fdiv`

## Requirements
- R1: A word is {sign at bit W−1, exponent field at bits W−2 down to 2M−1, fraction at bits 2M−2 down to 0}, with W = EXP_W+2M. The significand is 1.fraction, and as an integer it is 2^(2M−1) plus the fraction. Results use the same layout.
- R2: A result appears with `out_valid` high exactly 4 rising edges after the edge that samples `in_valid` high, counting that edge. `out_valid` is otherwise low. Operations can be issued on consecutive cycles and come out in issue order.
- R3: The table index is the divisor fraction bits 2M−2 down to M−1. Entry i equals floor((floor(2^(4M+2)/(2^M+i)^2)+1)/2), held in 2M+2 bits. The divisor low part is fraction bits M−2 down to 0.
- R4: Let D = (2^M+i)·2^(M−1) − low part. The first product is the dividend significand times D, shifted right by 2M−2. The second product is that value times the table entry.
- R5: If bit 4M+1 of the second product is set, the significand is bits 4M+1 down to 2M+2. Otherwise it is bits 4M down to 2M+1 and the exponent is lowered by one. The result fraction is the low 2M−1 bits of that significand.
- R6: The result sign is the XOR of the two operand signs.
- R7: The result exponent field is e_dividend − e_divisor + (2^(EXP_W−1)−1), less one when R5 shifts.
- R8: A divisor whose exponent field is zero is treated as zero and raises `out_exc` on its result.
- R9: `in_exc` high on an issued operation raises `out_exc` on that operation's result. `out_exc` is never high while `out_valid` is low.
- R10: If the exponent from R7 is below 1 or above 2^EXP_W−1, `out_exc` is raised. Exactly 1 and exactly 2^EXP_W−1 are valid.
- R11: When `out_exc` is high, `q_bits` is all zeros.
- R12: Without an exception, the result is within 4 units in its last place of the exact quotient of the two operand values.
- R13: While `rst` is high at a rising edge, the pipeline is cleared. After reset, `out_valid`, `out_exc` and `q_bits` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operand pair is presented this cycle |
| in_exc | input | 1 | Exception carried in from an upstream stage |
| a_bits | input | W | Dividend word |
| b_bits | input | W | Divisor word |
| out_valid | output | 1 | Result word is present |
| out_exc | output | 1 | Result is invalid (zero divisor, carried exception or exponent range) |
| q_bits | output | W | Quotient word |

## Verification
Every result is due exactly four rising edges after its operands are sampled. This applies to the quotient bits, the exception flag and the valid flag alike. When the driver issues an operation, it records the due cycle along with the expected word and flag. The monitor samples on the falling edge. It flags any result that arrives in a different cycle, that arrives with nothing pending, or that never arrives. Directed cases cover the normalization shift, divisors with a zero low part, both ends of the exponent range and each exception source. A long random stream, with and without gaps, checks ordering and accuracy.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    // Which path the output normalizer takes.
    typedef enum logic {
        NORM_KEEP  = 1'b0,
        NORM_SHIFT = 1'b1
    } norm_e;

    // Reciprocal-square entry for high part (2^m + idx) / 2^m,
    // scaled by 2^(2m+1) and rounded half up.
    function automatic logic [63:0] recip_sq_entry(input int unsigned m,
                                                   input int unsigned idx);
        logic [63:0] yh;
        logic [63:0] num;
        logic [63:0] q;
        yh  = (64'd1 << m) + 64'(idx);
        num = 64'd1 << (4 * m + 2);
        q   = num / (yh * yh);
        return (q + 64'd1) >> 1;
    endfunction

endpackage

// File: rtl/tfd_recip_rom.sv
module tfd_recip_rom #(
    parameter int M = 6
) (
    input  logic             clk,
    input  logic [M-1:0]     idx,
    output logic [2*M+1:0]   data
);
    import tfd_pkg::*;

    localparam int DEPTH = 1 << M;
    localparam int TW    = 2 * M + 2;

    logic [TW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tbl[i] = TW'(recip_sq_entry(M, i));
    end

    always_ff @(posedge clk) begin
        data <= tbl[idx];
    end

endmodule

// File: rtl/tfd_unpack.sv
module tfd_unpack #(
    parameter int EXP_W = 5,
    parameter int M     = 6,
    localparam int W    = EXP_W + 2 * M,
    localparam int XW   = EXP_W + 2
) (
    input  logic                  [W-1:0]   a_bits,
    input  logic                  [W-1:0]   b_bits,
    output logic                            sgn,
    output logic signed           [XW-1:0]  exp_pre,
    output logic                  [2*M-1:0] x_sig,
    output logic                  [2*M-1:0] d_sig,
    output logic                  [M-1:0]   tbl_idx,
    output logic                            div_zero
);
    localparam int FRAC_W = 2 * M - 1;
    localparam int SIG_W  = 2 * M;
    localparam logic signed [XW-1:0] BIAS = XW'((1 << (EXP_W - 1)) - 1);

    logic [EXP_W-1:0] ea;
    logic [EXP_W-1:0] eb;
    logic [SIG_W-1:0] y_sig;
    logic [M:0]       y_hi;
    logic [M-2:0]     y_lo;

    assign ea       = a_bits[W-2 -: EXP_W];
    assign eb       = b_bits[W-2 -: EXP_W];
    assign sgn      = a_bits[W-1] ^ b_bits[W-1];
    assign x_sig    = {1'b1, a_bits[FRAC_W-1:0]};
    assign y_sig    = {1'b1, b_bits[FRAC_W-1:0]};
    assign y_hi     = y_sig[SIG_W-1 -: M+1];
    assign y_lo     = y_sig[M-2:0];
    assign tbl_idx  = y_sig[SIG_W-2 -: M];

    // High part minus low part, both on the 2^-(2M-1) grid.
    assign d_sig    = {y_hi, {(M-1){1'b0}}} - SIG_W'(y_lo);

    assign exp_pre  = $signed({2'b00, ea}) - $signed({2'b00, eb}) + BIAS;
    assign div_zero = (eb == '0);

endmodule

// File: rtl/tfd_pack.sv
module tfd_pack #(
    parameter int EXP_W = 5,
    parameter int M     = 6,
    localparam int W    = EXP_W + 2 * M,
    localparam int XW   = EXP_W + 2,
    localparam int P2_W = 4 * M + 4
) (
    input  logic                  [P2_W-1:0] prod,
    input  logic signed           [XW-1:0]   exp_pre,
    input  logic                             sgn,
    input  logic                             exc_in,
    output logic                  [W-1:0]    q_bits,
    output logic                             exc_out
);
    import tfd_pkg::*;

    localparam int FRAC_W = 2 * M - 1;
    localparam logic signed [XW-1:0] ONE    = XW'(1);
    localparam logic signed [XW-1:0] EXP_LO = XW'(1);
    localparam logic signed [XW-1:0] EXP_HI = XW'((1 << EXP_W) - 1);

    norm_e                   mode;
    logic [FRAC_W-1:0]       mant;
    logic signed [XW-1:0]    exp_fin;
    logic                    range_bad;

    always_comb begin
        mode = prod[4*M+1] ? NORM_KEEP : NORM_SHIFT;
        if (mode == NORM_KEEP) begin
            mant    = FRAC_W'(prod >> (2 * M + 2));
            exp_fin = exp_pre;
        end else begin
            mant    = FRAC_W'(prod >> (2 * M + 1));
            exp_fin = exp_pre - ONE;
        end
        range_bad = (exp_fin < EXP_LO) || (exp_fin > EXP_HI);
        exc_out   = exc_in | range_bad;
        q_bits    = exc_out ? '0 : {sgn, exp_fin[EXP_W-1:0], mant};
    end

endmodule

// File: rtl/taylor_fdiv.sv
module taylor_fdiv #(
    parameter int EXP_W = 5,
    parameter int M     = 6,
    localparam int W    = EXP_W + 2 * M
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_exc,
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    output logic         out_valid,
    output logic         out_exc,
    output logic [W-1:0] q_bits
);
    localparam int SIG_W = 2 * M;
    localparam int XW    = EXP_W + 2;
    localparam int TW    = 2 * M + 2;
    localparam int P1_W  = 4 * M;
    localparam int P1T_W = 2 * M + 2;
    localparam int P2_W  = 4 * M + 4;

    typedef struct packed {
        logic                 vld;
        logic                 exc;
        logic                 sgn;
        logic signed [XW-1:0] ex;
    } ctl_t;

    // Operand decode
    logic                 sgn_c;
    logic signed [XW-1:0] exp_c;
    logic [SIG_W-1:0]     x_c;
    logic [SIG_W-1:0]     d_c;
    logic [M-1:0]         idx_c;
    logic                 dz_c;
    ctl_t                 c_in;

    tfd_unpack #(.EXP_W(EXP_W), .M(M)) u_unpack (
        .a_bits   (a_bits),
        .b_bits   (b_bits),
        .sgn      (sgn_c),
        .exp_pre  (exp_c),
        .x_sig    (x_c),
        .d_sig    (d_c),
        .tbl_idx  (idx_c),
        .div_zero (dz_c)
    );

    always_comb begin
        c_in.vld = in_valid;
        c_in.exc = in_valid & (in_exc | dz_c);
        c_in.sgn = sgn_c;
        c_in.ex  = exp_c;
    end

    // Stage 1: operands captured, table read in parallel
    ctl_t             c1;
    ctl_t             c2;
    ctl_t             c3;
    logic [SIG_W-1:0] x1;
    logic [SIG_W-1:0] d1;
    logic [TW-1:0]    t1;
    logic [TW-1:0]    t2;
    logic [P1_W-1:0]  p1_2;
    logic [P1T_W-1:0] p1t;
    logic [P2_W-1:0]  p2_3;

    tfd_recip_rom #(.M(M)) u_rom (
        .clk  (clk),
        .idx  (idx_c),
        .data (t1)
    );

    assign p1t = P1T_W'(p1_2 >> (2 * M - 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            c1 <= '0;
            c2 <= '0;
            c3 <= '0;
        end else begin
            c1 <= c_in;
            c2 <= c1;
            c3 <= c2;
        end
        x1   <= x_c;
        d1   <= d_c;
        p1_2 <= P1_W'(x1) * P1_W'(d1);
        t2   <= t1;
        p2_3 <= P2_W'(p1t) * P2_W'(t2);
    end

    // Stage 4: normalize, range check, pack
    logic [W-1:0] q_c;
    logic         exc_c;

    tfd_pack #(.EXP_W(EXP_W), .M(M)) u_pack (
        .prod    (p2_3),
        .exp_pre (c3.ex),
        .sgn     (c3.sgn),
        .exc_in  (c3.exc),
        .q_bits  (q_c),
        .exc_out (exc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_exc   <= 1'b0;
            q_bits    <= '0;
        end else begin
            out_valid <= c3.vld;
            out_exc   <= c3.vld & exc_c;
            q_bits    <= c3.vld ? q_c : '0;
        end
    end

endmodule

// File: rtl/tfd_chk.sv
module tfd_chk #(
    parameter int EXP_W = 5,
    parameter int M     = 6,
    localparam int W    = EXP_W + 2 * M
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_exc,
    input logic             a_sgn,
    input logic             b_sgn,
    input logic [EXP_W-1:0] b_exp,
    input logic             out_valid,
    input logic             out_exc,
    input logic [W-1:0]     q_bits
);
    // Edges since reset, saturating at the pipeline depth.
    logic [2:0] since;
    always_ff @(posedge clk) begin
        if (rst)              since <= 3'd0;
        else if (since != 3'd4) since <= since + 3'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    p_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (since == 3'd4 && out_valid && !out_exc)
            |-> (q_bits[W-1] == ($past(a_sgn, 4) ^ $past(b_sgn, 4))));

    p_zero_div_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_exp == '0) |-> ##4 (out_valid && out_exc));

    p_exc_carry_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_exc) |-> ##4 (out_valid && out_exc));

    p_exc_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_exc |-> out_valid);

    p_exp_range_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_exc) |-> (q_bits[W-2 -: EXP_W] != '0));

    p_zeroed_r11: assert property (@(posedge clk) disable iff (rst)
        out_exc |-> (q_bits == '0));

endmodule

bind taylor_fdiv tfd_chk #(.EXP_W(EXP_W), .M(M)) i_tfd_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_exc    (in_exc),
    .a_sgn     (a_bits[W-1]),
    .b_sgn     (b_bits[W-1]),
    .b_exp     (b_bits[W-2 -: EXP_W]),
    .out_valid (out_valid),
    .out_exc   (out_exc),
    .q_bits    (q_bits)
);

// File: tb/test_taylor_fdiv.sv
module test_taylor_fdiv;
    localparam int E    = 5;
    localparam int M    = 6;
    localparam int F    = 2 * M - 1;
    localparam int W    = E + 2 * M;
    localparam int BIAS = (1 << (E - 1)) - 1;
    localparam int LAT  = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_exc = 1'b0;
    logic [W-1:0] a_bits = '0;
    logic [W-1:0] b_bits = '0;
    logic         out_valid;
    logic         out_exc;
    logic [W-1:0] q_bits;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] q;
        logic         exc;
        int           due;
        string        tag;
    } item_t;

    item_t sb[$];

    taylor_fdiv i_taylor_fdiv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_exc    (in_exc),
        .a_bits    (a_bits),
        .b_bits    (b_bits),
        .out_valid (out_valid),
        .out_exc   (out_exc),
        .q_bits    (q_bits)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] mk(input logic s, input int unsigned e, input int unsigned f);
        return {s, E'(e), F'(f)};
    endfunction

    // Expected result from R1, R3-R11
    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input logic ei,
                                  output logic [W-1:0] q, output logic ex);
        longint xs, ys, yh, yl, dd, p1t, tv, p2, mant;
        int     ea, eb, ef;
        bit     hi;
        xs   = (longint'(1) << F) | longint'(a[F-1:0]);
        ys   = (longint'(1) << F) | longint'(b[F-1:0]);
        yh   = ys >> (M - 1);
        yl   = ys & ((longint'(1) << (M - 1)) - 1);
        dd   = (yh << (M - 1)) - yl;
        p1t  = (xs * dd) >> (2 * M - 2);
        tv   = (((longint'(1) << (4 * M + 2)) / (yh * yh)) + 1) >> 1;
        p2   = p1t * tv;
        hi   = ((p2 >> (4 * M + 1)) & 1) != 0;
        mant = hi ? (p2 >> (2 * M + 2)) : (p2 >> (2 * M + 1));
        ea   = int'(a[W-2 -: E]);
        eb   = int'(b[W-2 -: E]);
        ef   = ea - eb + BIAS - (hi ? 0 : 1);
        ex   = ei || (eb == 0) || (ef < 1) || (ef > (1 << E) - 1);
        q    = ex ? '0 : {a[W-1] ^ b[W-1], E'(ef), F'(mant)};
    endfunction

    // R12: closeness to the exact quotient
    task automatic accuracy(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] q);
        real xa, yb, qe, sg, ulp, err;
        int  d;
        xa  = 1.0 + real'(a[F-1:0]) / real'(1 << F);
        yb  = 1.0 + real'(b[F-1:0]) / real'(1 << F);
        qe  = xa / yb;
        sg  = 1.0 + real'(q[F-1:0]) / real'(1 << F);
        ulp = 1.0 / real'(1 << F);
        d   = int'(q[W-2 -: E]) - (int'(a[W-2 -: E]) - int'(b[W-2 -: E]) + BIAS);
        if (d == -1) begin
            sg  = sg * 0.5;
            ulp = ulp * 0.5;
        end
        err = qe - sg;
        if (err < 0.0) err = -err;
        check((d == 0 || d == -1) && err < 4.0 * ulp, "R12 accuracy",
              longint'(q), longint'($rtoi(qe * real'(1 << F))));
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic e, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_exc   = e;
        a_bits   = a;
        b_bits   = b;
        it.a   = a;
        it.b   = b;
        model(a, b, e, it.q, it.exc);
        it.due = cyc + LAT;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_exc   = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 result with nothing pending", longint'(q_bits), 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(cyc == it.due, {it.tag, " R2 latency"}, cyc, it.due);
                    check(out_exc == it.exc, {it.tag, " exception"}, out_exc, it.exc);
                    check(q_bits == it.q, {it.tag, " result"}, q_bits, it.q);
                    if (!it.exc) accuracy(it.a, it.b, q_bits);
                end
            end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                check(1'b0, {sb[0].tag, " R2 missing result"}, 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        check(out_valid == 1'b0, "R13 out_valid after reset", out_valid, 0);
        check(out_exc == 1'b0, "R13 out_exc after reset", out_exc, 0);
        check(q_bits == '0, "R13 q_bits after reset", q_bits, 0);
        idle(2);

        // R1/R7: 1.0 / 1.0 gives 1.0 with the dividend exponent unchanged
        send(mk(0, 15, 0), mk(0, 15, 0), 0, "R1 R7 unit");
        idle(1);
        check(sb.size() == 1, "R1 queue", sb.size(), 1);
        begin
            logic [W-1:0] qx;
            logic         ex;
            model(mk(0, 15, 0), mk(0, 15, 0), 0, qx, ex);
            check(qx == mk(0, 15, 0) && !ex, "R1 R7 unit reference", qx, mk(0, 15, 0));
        end
        send(mk(0, 18, 1024), mk(0, 16, 0), 0, "R7 1.5x4/1");
        idle(6);

        // R6: all sign pairs
        send(mk(0, 16, 300), mk(0, 14, 777), 0, "R6 ++");
        send(mk(1, 16, 300), mk(0, 14, 777), 0, "R6 -+");
        send(mk(0, 16, 300), mk(1, 14, 777), 0, "R6 +-");
        send(mk(1, 16, 300), mk(1, 14, 777), 0, "R6 --");
        idle(6);

        // R3: divisors with a zero low part, every table region
        for (int i = 0; i < (1 << M); i += 7) begin
            send(mk(0, 15, 1500), mk(0, 15, i << (M - 1)), 0, "R3 zero low part");
        end
        send(mk(0, 15, 0), mk(0, 15, ((1 << M) - 1) << (M - 1)), 0, "R3 last entry");
        idle(6);

        // R5: quotient below one takes the shift path
        send(mk(0, 15, 0), mk(0, 15, (1 << F) - 1), 0, "R5 shift max divisor");
        send(mk(0, 15, 5), mk(0, 15, 900), 0, "R5 shift");
        send(mk(0, 15, (1 << F) - 1), mk(0, 15, 0), 0, "R5 keep near two");
        idle(6);

        // R8, R11: zero divisor
        send(mk(0, 15, 123), mk(0, 0, 0), 0, "R8 R11 zero divisor");
        send(mk(1, 20, 7), mk(0, 0, 55), 0, "R8 R11 zero exp field");
        // R9: carried exception
        send(mk(0, 15, 10), mk(0, 15, 20), 1, "R9 exc in");
        send(mk(0, 15, 10), mk(0, 15, 20), 0, "R9 clean neighbour");
        idle(6);

        // R10: exponent range edges
        send(mk(0, 31, 0), mk(0, 1, 0), 0, "R10 overflow");
        send(mk(0, 1, 0), mk(0, 30, 2047), 0, "R10 underflow");
        send(mk(0, 31, 0), mk(0, 15, 0), 0, "R10 top edge valid");
        send(mk(0, 1, 0), mk(0, 15, 0), 0, "R10 bottom edge valid");
        send(mk(0, 1, 0), mk(0, 15, 1), 0, "R10 shift to zero");
        idle(6);

        // R2/R4/R12: random stream, back to back and with gaps
        for (int n = 0; n < 600; n++) begin
            send(mk(1'($urandom_range(0, 1)), $urandom_range(5, 26), $urandom_range(0, (1 << F) - 1)),
                 mk(1'($urandom_range(0, 1)), $urandom_range(5, 26), $urandom_range(0, (1 << F) - 1)),
                 ($urandom_range(0, 31) == 0), "R2 R4 R12 stream");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(LAT + 4);
        check(sb.size() == 0, "R2 all results drained", sb.size(), 0);
        finish_run();
    end

endmodule